// File: doc/BRIEF.md
# Serial ADC Readout Controller

This block is the host side of a three-wire link to a 12-bit sampling ADC. The link has an active-low chip select, a data clock that the host drives, and one data line from the converter. A one-cycle start request in the idle state lowers chip select and makes the block toggle the data clock at a rate set by a divider parameter. The converter uses the first clock periods to sample its input and then sends one low null bit. After that it sends the result with the most significant bit first. The controller drops the lead-in and null periods and shifts the word in on rising clock edges, because the converter changes its line on falling edges.

In compare mode the frame runs for eleven more clock periods. During these the converter sends the word again, least significant bit first and starting at B1. The controller rebuilds that copy and raises a mismatch flag when it does not agree with the first copy. At the end of every frame chip select goes high and stays high for a full clock period. The result is then presented with a one-cycle valid strobe. A busy output covers the span from the accepted start request up to that strobe.

Top module: `sadc_reader`

## Requirements
- R1: After reset the outputs are as follows: chip select high (`cs_n_o`=1), data clock low, `busy_o`=0, `valid_o`=0, `result_o`=0 and `mismatch_o`=0.
- R2: A start request sampled in the idle state gives `cs_n_o`=0 and `busy_o`=1 in the next cycle. The data clock then stays low for HALF_DIV system clocks before its first rising edge.
- R3: Each high half and each low half of the data clock lasts exactly HALF_DIV system clocks. The data clock is low whenever chip select is high.
- R4: A frame has exactly 15 rising data-clock edges in normal mode and exactly 26 in compare mode.
- R5: The data line is sampled in the system clock cycle in which the data clock goes high. Edges 1 to 3 are discarded, covering sampling and the null bit. Edges 4 to 15 carry B11 down to B0.
- R6: The result is straight binary: 0x000 is zero input, 0x800 is mid-scale and 0xFFF is full scale. It appears with `valid_o` high for exactly one system clock and holds until the next strobe.
- R7: After a frame, chip select stays high for at least 2*HALF_DIV system clocks before the valid strobe. `busy_o` falls in the same cycle that `valid_o` rises.
- R8: A start request while `busy_o` is high is ignored. It neither restarts the current frame nor queues a new one.
- R9: In compare mode, edges 16 to 26 carry B1 up to B11. `mismatch_o` is 1 exactly when that copy differs from bits B11..B1 of the first copy. In normal mode `mismatch_o` is 0.
- R10: The mode is taken from `cmp_mode_i` when the start request is accepted. Changes to that input during the frame have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request to read one conversion |
| cmp_mode_i | input | 1 | 1 selects compare mode for the requested frame |
| sdata_i | input | 1 | Serial data from the converter |
| cs_n_o | output | 1 | Active-low chip select to the converter |
| sclk_o | output | 1 | Data clock to the converter |
| busy_o | output | 1 | High from accepted start until the valid strobe |
| valid_o | output | 1 | One-cycle strobe marking a new result |
| result_o | output | 12 | Conversion result, straight binary |
| mismatch_o | output | 1 | Compare mode: the two copies disagreed |

## Verification
A behavioural converter model drives the data line from the falling clock edges. It is fed the corner codes 0x000, 0xFFF, 0x800 and 0x7FF in both modes, followed by a set of random words. The all-zero and all-one codes show whether the null bit or the lead-in periods are being captured by mistake. The mid-scale pair shows a one-position shift or a bit-order reversal. Frames with a single corrupted bit in the repeated copy tell a working compare apart from a flag that is stuck, and flipping the mode input during every frame, together with a start pulse mid-frame, shows that both are ignored once a frame is running.

// File: rtl/sadc_pkg.sv
package sadc_pkg;
    localparam int RD_DATA_W_DEF = 12;

    typedef enum logic [1:0] {
        RD_IDLE = 2'd0,
        RD_RUN  = 2'd1,
        RD_GAP  = 2'd2
    } rd_state_e;
endpackage

// File: rtl/sadc_tick.sv
module sadc_tick #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic tick_o
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] CNT_MAX = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick_o = en_i && (cnt_q == CNT_MAX);
        if (!en_i || tick_o) cnt_d = '0;
        else                 cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/sadc_capture.sv
module sadc_capture #(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              shift_msb_i,
    input  logic              shift_lsb_i,
    input  logic              bit_i,
    output logic [DATA_W-1:0] word_o,
    output logic              differ_o
);
    logic [DATA_W-1:0] fwd_d, fwd_q;
    logic [DATA_W-2:0] rev_d, rev_q;   // rev_q[i] holds bit i+1

    always_comb begin
        fwd_d = fwd_q;
        rev_d = rev_q;
        if (clear_i) begin
            fwd_d = '0;
            rev_d = '0;
        end else if (shift_msb_i) begin
            fwd_d = {fwd_q[DATA_W-2:0], bit_i};
        end else if (shift_lsb_i) begin
            if (DATA_W > 2) rev_d = {bit_i, rev_q[DATA_W-2:1]};
            else            rev_d = bit_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fwd_q <= '0;
            rev_q <= '0;
        end else begin
            fwd_q <= fwd_d;
            rev_q <= rev_d;
        end
    end

    assign word_o   = fwd_q;
    assign differ_o = (rev_q != fwd_q[DATA_W-1:1]);

    // R5/R9: one bit goes to only one copy per edge
    p_one_copy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(shift_msb_i && shift_lsb_i));
endmodule

// File: rtl/sadc_reader.sv
module sadc_reader
    import sadc_pkg::*;
#(
    parameter int DATA_W     = RD_DATA_W_DEF,
    parameter int HALF_DIV   = 4,
    parameter int LEAD_EDGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              cmp_mode_i,
    input  logic              sdata_i,
    output logic              cs_n_o,
    output logic              sclk_o,
    output logic              busy_o,
    output logic              valid_o,
    output logic [DATA_W-1:0] result_o,
    output logic              mismatch_o
);
    localparam int NULL_EDGE = LEAD_EDGES + 1;
    localparam int MSB_LAST  = NULL_EDGE + DATA_W;
    localparam int LSB_LAST  = MSB_LAST + DATA_W - 1;
    localparam int EW        = $clog2(LSB_LAST + 1);
    localparam logic [EW-1:0] E_MSB_FIRST = EW'(NULL_EDGE + 1);
    localparam logic [EW-1:0] E_MSB_LAST  = EW'(MSB_LAST);
    localparam logic [EW-1:0] E_LSB_LAST  = EW'(LSB_LAST);

    typedef struct packed {
        rd_state_e         st;
        logic              cs_n;
        logic              sclk;
        logic [EW-1:0]     edge_n;
        logic              cmp;
        logic              gap_half;
        logic              valid;
        logic [DATA_W-1:0] result;
        logic              mismatch;
    } regs_t;

    regs_t r_d, r_q;

    logic              tick;
    logic              cap_clear, cap_msb, cap_lsb;
    logic [DATA_W-1:0] cap_word;
    logic              cap_differ;
    logic [EW-1:0]     edge_next, edge_last;

    sadc_tick #(.HALF_DIV(HALF_DIV)) tick_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (r_q.st != RD_IDLE),
        .tick_o (tick)
    );

    sadc_capture #(.DATA_W(DATA_W)) cap_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_i     (cap_clear),
        .shift_msb_i (cap_msb),
        .shift_lsb_i (cap_lsb),
        .bit_i       (sdata_i),
        .word_o      (cap_word),
        .differ_o    (cap_differ)
    );

    assign edge_next = r_q.edge_n + 1'b1;
    assign edge_last = r_q.cmp ? E_LSB_LAST : E_MSB_LAST;

    always_comb begin
        r_d       = r_q;
        r_d.valid = 1'b0;
        cap_clear = 1'b0;
        cap_msb   = 1'b0;
        cap_lsb   = 1'b0;
        unique case (r_q.st)
            RD_IDLE: begin
                if (start_i) begin
                    r_d.st     = RD_RUN;
                    r_d.cs_n   = 1'b0;
                    r_d.sclk   = 1'b0;
                    r_d.edge_n = '0;
                    r_d.cmp    = cmp_mode_i;
                    cap_clear  = 1'b1;
                end
            end
            RD_RUN: begin
                if (tick) begin
                    if (!r_q.sclk) begin
                        r_d.sclk   = 1'b1;
                        r_d.edge_n = edge_next;
                        if (edge_next >= E_MSB_FIRST && edge_next <= E_MSB_LAST)
                            cap_msb = 1'b1;
                        else if (edge_next > E_MSB_LAST)
                            cap_lsb = 1'b1;
                    end else begin
                        r_d.sclk = 1'b0;
                        if (r_q.edge_n == edge_last) begin
                            r_d.cs_n     = 1'b1;
                            r_d.st       = RD_GAP;
                            r_d.gap_half = 1'b0;
                        end
                    end
                end
            end
            RD_GAP: begin
                if (tick) begin
                    if (r_q.gap_half) begin
                        r_d.st       = RD_IDLE;
                        r_d.valid    = 1'b1;
                        r_d.result   = cap_word;
                        r_d.mismatch = r_q.cmp && cap_differ;
                    end else begin
                        r_d.gap_half = 1'b1;
                    end
                end
            end
            default: r_d.st = RD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q          <= '0;
            r_q.st       <= RD_IDLE;
            r_q.cs_n     <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign cs_n_o     = r_q.cs_n;
    assign sclk_o     = r_q.sclk;
    assign busy_o     = (r_q.st != RD_IDLE);
    assign valid_o    = r_q.valid;
    assign result_o   = r_q.result;
    assign mismatch_o = r_q.mismatch;

    p_idle_cs_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> cs_n_o);
    p_start_taken_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> (!cs_n_o && busy_o));
    p_sclk_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_o |-> !sclk_o);
    p_edge_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.edge_n <= edge_last);
    p_valid_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);
    p_busy_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> valid_o);
    p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == RD_RUN && start_i && !tick) |=> (r_q.st == RD_RUN && $stable(r_q.edge_n)));
    p_no_flag_normal_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !r_q.cmp) |-> !mismatch_o);
endmodule

// File: tb/sadc_reader_tb_top.sv
module sadc_reader_tb_top;
    localparam int CLK_PER = 10;
    localparam int HALF    = 4;
    localparam int DW      = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic cmp_mode = 1'b0;
    logic sdata = 1'b1;
    logic cs_n, sclk, busy, valid, mismatch;
    logic [DW-1:0] result;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    logic [DW-1:0] adc_word = '0;
    bit corrupt = 1'b0;
    int falls = 0;
    int rises = 0;
    int per_err = 0;
    int lead_err = 0;
    int cs_fall_cyc = 0;
    int cs_rise_cyc = 0;
    int seg_start = 0;
    bit first_rise = 1'b0;
    logic prev_sclk = 1'b0;
    logic prev_cs = 1'b1;

    sadc_reader #(.DATA_W(DW), .HALF_DIV(HALF), .LEAD_EDGES(2)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .cmp_mode_i (cmp_mode),
        .sdata_i    (sdata),
        .cs_n_o     (cs_n),
        .sclk_o     (sclk),
        .busy_o     (busy),
        .valid_o    (valid),
        .result_o   (result),
        .mismatch_o (mismatch)
    );

    always #(CLK_PER/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic adc_bit(int f, logic [DW-1:0] w, bit bad);
        if (f == 2) return 1'b0;
        if (f >= 3 && f <= 14) return w[14 - f];
        if (f >= 15 && f <= 25) return w[f - 14] ^ (bad && f == 20);
        return 1'b0;
    endfunction

    // converter model and link monitor, evaluated away from the active edge
    always @(negedge clk) begin
        if (prev_cs && !cs_n) begin
            cs_fall_cyc = cyc;
            falls = 0;
            sdata = 1'b1;
            first_rise = 1'b1;
            seg_start = cyc;
        end
        if (!prev_cs && cs_n) cs_rise_cyc = cyc;
        if (cs_n && sclk) per_err++;
        if (!prev_sclk && sclk) begin
            rises++;
            if (first_rise) begin
                if (cyc - cs_fall_cyc != HALF) lead_err++;
                first_rise = 1'b0;
            end else if (cyc - seg_start != HALF) per_err++;
            seg_start = cyc;
        end
        if (prev_sclk && !sclk) begin
            if (cyc - seg_start != HALF) per_err++;
            seg_start = cyc;
            if (!cs_n) begin
                falls++;
                sdata = adc_bit(falls, adc_word, corrupt);
            end
        end
        prev_sclk = sclk;
        prev_cs = cs_n;
    end

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_frame(logic [DW-1:0] w, bit cm, bit bad);
        int guard;
        logic [DW-1:0] held;
        adc_word = w;
        corrupt = bad;
        rises = 0;
        start = 1'b1;
        cmp_mode = cm;
        @(negedge clk);
        start = 1'b0;
        cmp_mode = ~cm;   // R10: must not affect the running frame
        @(negedge clk);
        chk(!cs_n && busy, "R2 start taken", {cs_n, busy}, 2'b01);
        repeat (20) @(negedge clk);
        start = 1'b1;     // R8: request while busy
        @(negedge clk);
        start = 1'b0;
        guard = 0;
        while (!valid && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        chk(valid, "R6 valid seen", valid, 1);
        chk(result == w, "R5 R6 result", result, w);
        chk(mismatch == (cm && bad), "R9 R10 mismatch", mismatch, cm && bad);
        chk(rises == (cm ? 26 : 15), "R4 edge count", rises, cm ? 26 : 15);
        chk(!busy, "R7 busy low at strobe", busy, 0);
        chk(cyc - cs_rise_cyc >= 2 * HALF, "R7 gap", cyc - cs_rise_cyc, 2 * HALF);
        held = result;
        @(negedge clk);
        chk(!valid && result == held, "R6 single strobe and hold", {valid, result}, {1'b0, held});
        repeat (40) @(negedge clk);
        chk(cs_n && !busy, "R8 no queued frame", {cs_n, busy}, 2'b10);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 200000);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        chk(cs_n && !sclk && !busy && !valid && result == 0 && !mismatch,
            "R1 reset state", {cs_n, sclk, busy, valid, mismatch}, 5'b10000);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cs_n && !busy, "R1 idle after reset", {cs_n, busy}, 2'b10);

        do_frame(12'h000, 1'b0, 1'b0);
        do_frame(12'hFFF, 1'b0, 1'b0);
        do_frame(12'h800, 1'b0, 1'b0);
        do_frame(12'h7FF, 1'b0, 1'b0);
        do_frame(12'h000, 1'b1, 1'b0);
        do_frame(12'hFFF, 1'b1, 1'b0);
        do_frame(12'h800, 1'b1, 1'b1);
        do_frame(12'h7FF, 1'b1, 1'b1);
        for (int i = 0; i < 24; i++) begin
            do_frame(DW'($urandom), 1'($urandom), 1'($urandom));
        end

        chk(per_err == 0, "R3 clock halves", per_err, 0);
        chk(lead_err == 0, "R2 first low half", lead_err, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule